// File: doc/BRIEF.md
# DRAM Mode Register Programming Sequencer

This block sits on the controller side of a DDR3-style DRAM interface and turns a request to program one of the four mode registers into a single-cycle mode-register-set command on the bank-address and address lines. Writes to registers 0, 2 and 3 take a raw address word. Writes to register 1 take a set of decoded fields: DLL control, drive strength, additive latency, nominal termination, write leveling, the termination data strobe enable and the output disable. The block places each field on its address bit and refuses any encoding that is reserved or not allowed in the current write-leveling setup.

An accepted request is held until the memory reports that all banks are idle and no burst is running. The command is then driven for one cycle, and the command spacing rules are enforced: a minimum gap before the next mode-register command and a longer gap before any other command. The `busy` output covers both gaps. A shadow copy of every register is kept and can be read back. When a register-1 write moves the DLL from disabled to enabled, the block follows it with a register-0 write that has the DLL-reset bit set.

Top module: `mrs_seq`

## Requirements
- R1: The command drives `cmd_ba[1:0]` equal to the target select (00 register 0, 01 register 1, 10 register 2, 11 register 3) and `cmd_ba[2]` low. For registers 0, 2 and 3 `cmd_addr` equals `req_addr`.
- R2: For register 1 the fields land on these `cmd_addr` bits. DLL off is on bit 0. Drive code {bit5,bit1} uses 00 = RZQ/6 and 01 = RZQ/7. Additive latency {bit4,bit3} uses 00 = off, 01 = CL-1 and 10 = CL-2. Termination {bit9,bit6,bit2} uses 000 = off, 001 = RZQ/4, 010 = RZQ/2, 011 = RZQ/6, 100 = RZQ/12 and 101 = RZQ/8. Write leveling is on bit 7, the strobe enable on bit 11 and output disable on bit 12.
- R3: In a register-1 command, bits 13, 10 and 8 of `cmd_addr` and `cmd_ba[2]` are always 0, and `req_addr` has no effect.
- R4: A register-1 request whose drive code is 10 or 11 is rejected.
- R5: A register-1 request whose additive latency code is 11 is rejected.
- R6: A register-1 request whose termination code is 110 or 111 is rejected.
- R7: When write leveling is on and output disable is clear, only termination codes 001, 010 and 011 are accepted. When write leveling is on and output disable is set, codes 000 to 101 are accepted.
- R8: A rejected request raises `err` for exactly one cycle, the cycle after acceptance. It drives no command, leaves `busy` low and leaves the shadow unchanged.
- R9: An accepted request raises `busy` in the next cycle. The command appears one cycle after a clock edge at which `banks_idle` is high and `burst_active` is low, and not before.
- R10: `cmd_mrs` is high for single cycles. Two commands are at least T_MRD cycles apart. `busy` falls exactly T_MOD cycles after the last command.
- R11: When a register-1 write clears the DLL-off bit while the shadow holds it set, a register-0 command follows exactly T_MRD cycles later. Its word is the register-0 shadow with bit 8 set.
- R12: Shadows reset to 0. Each one takes the word of every command issued to it. A request made while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_sel | input | 2 | Target register select |
| req_addr | input | ADDR_W | Raw word for registers 0, 2 and 3 |
| req_dll_off | input | 1 | Register 1: 1 disables the DLL |
| req_drive | input | 2 | Register 1: drive strength code |
| req_addlat | input | 2 | Register 1: additive latency code |
| req_term | input | 3 | Register 1: nominal termination code |
| req_wlev | input | 1 | Register 1: write leveling enable |
| req_tdqs | input | 1 | Register 1: termination data strobe enable |
| req_out_off | input | 1 | Register 1: output disable |
| banks_idle | input | 1 | All banks idle |
| burst_active | input | 1 | A burst is in progress |
| cmd_mrs | output | 1 | Mode-register-set command strobe |
| cmd_ba | output | 3 | Bank address of the command |
| cmd_addr | output | ADDR_W | Address bus of the command |
| busy | output | 1 | Request in flight or spacing window open |
| err | output | 1 | One-cycle reject pulse |
| shadow_sel | input | 2 | Shadow read select |
| shadow_word | output | ADDR_W | Selected shadow contents |

## Verification
The bench builds the block with T_MRD = 3 and T_MOD = 7, in place of the defaults 4 and 12. These values are small and unequal. Every command-spacing window can then be checked cycle by cycle in a short run, and the gap before the automatic DLL-reset write (3 cycles) stays clearly separate from the release of `busy` (7 cycles later). ADDR_W stays at 14, the smallest width that still holds the highest register-1 field and the reserved bit 13.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

    localparam int BA_W   = 3;
    localparam int SEL_W  = 2;
    localparam int N_MR   = 4;

    typedef enum logic [SEL_W-1:0] {
        MR_ID0 = 2'd0,
        MR_ID1 = 2'd1,
        MR_ID2 = 2'd2,
        MR_ID3 = 2'd3
    } mr_id_e;

    // register-1 field positions on the address bus
    localparam int B_DLL    = 0;
    localparam int B_DRV_LO = 1;
    localparam int B_TRM_0  = 2;
    localparam int B_AL_LO  = 3;
    localparam int B_AL_HI  = 4;
    localparam int B_DRV_HI = 5;
    localparam int B_TRM_1  = 6;
    localparam int B_WLEV   = 7;
    localparam int B_TRM_2  = 9;
    localparam int B_TDQS   = 11;
    localparam int B_QOFF   = 12;
    localparam int MR1_TOP  = 13;   // highest reserved bit that must be driven low

    localparam int B_DLL_RESET = 8;  // register-0 DLL reset

    typedef struct packed {
        logic       dll_off;
        logic [1:0] drive;
        logic [1:0] addlat;
        logic [2:0] term;
        logic       wlev;
        logic       tdqs_en;
        logic       out_off;
    } mr1_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_GAP,
        ST_SETTLE
    } seq_state_e;

    function automatic logic mr1_legal(input mr1_cfg_t c);
        logic ok;
        ok = 1'b1;
        if (c.drive[1])          ok = 1'b0;
        if (c.addlat == 2'b11)   ok = 1'b0;
        if (c.term[2:1] == 2'b11) ok = 1'b0;
        if (c.wlev && !c.out_off && (c.term == 3'b000 || c.term[2])) ok = 1'b0;
        return ok;
    endfunction

endpackage

// File: rtl/mrs_mr1_pack.sv
module mrs_mr1_pack
    import mrs_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  mr1_cfg_t          cfg,
    output logic [ADDR_W-1:0] word,
    output logic              legal
);
    always_comb begin
        word           = '0;
        word[B_DLL]    = cfg.dll_off;
        word[B_DRV_LO] = cfg.drive[0];
        word[B_DRV_HI] = cfg.drive[1];
        word[B_AL_LO]  = cfg.addlat[0];
        word[B_AL_HI]  = cfg.addlat[1];
        word[B_TRM_0]  = cfg.term[0];
        word[B_TRM_1]  = cfg.term[1];
        word[B_TRM_2]  = cfg.term[2];
        word[B_WLEV]   = cfg.wlev;
        word[B_TDQS]   = cfg.tdqs_en;
        word[B_QOFF]   = cfg.out_off;
        legal          = mr1_legal(cfg);
    end

    initial begin
        assert (ADDR_W > MR1_TOP) else $error("ADDR_W too narrow for register 1");
    end
endmodule

// File: rtl/mrs_shadow.sv
module mrs_shadow
    import mrs_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [ADDR_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mr0_word,
    output logic              mr1_dll_off
);
    logic [ADDR_W-1:0] regs [N_MR];

    for (genvar g = 0; g < N_MR; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (wr_en && wr_sel == SEL_W'(g))
                regs[g] <= wr_data;
        end
    end

    assign rd_data     = regs[rd_sel];
    assign mr0_word    = regs[0];
    assign mr1_dll_off = regs[1][B_DLL];

    // R12: a shadow holds its value unless written
    p_shadow_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs[1]));
endmodule

// File: rtl/mrs_gap_timer.sv
module mrs_gap_timer #(
    parameter int T_MRD = 4,
    parameter int T_MOD = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic mrd_last,
    output logic mod_last
);
    localparam int CNT_W = $clog2(T_MOD + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= CNT_W'(T_MOD);
        else if (start)
            cnt <= '0;
        else if (cnt != CNT_W'(T_MOD))
            cnt <= cnt + 1'b1;
    end

    assign mrd_last = (cnt == CNT_W'(T_MRD - 1));
    assign mod_last = (cnt == CNT_W'(T_MOD - 1));

    initial begin
        assert (T_MRD >= 1 && T_MOD >= T_MRD) else $error("bad spacing parameters");
    end
endmodule

// File: rtl/mrs_seq.sv
module mrs_seq
    import mrs_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int T_MRD  = 4,
    parameter int T_MOD  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_sel,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_dll_off,
    input  logic [1:0]        req_drive,
    input  logic [1:0]        req_addlat,
    input  logic [2:0]        req_term,
    input  logic              req_wlev,
    input  logic              req_tdqs,
    input  logic              req_out_off,
    input  logic              banks_idle,
    input  logic              burst_active,
    output logic              cmd_mrs,
    output logic [2:0]        cmd_ba,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              busy,
    output logic              err,
    input  logic [1:0]        shadow_sel,
    output logic [ADDR_W-1:0] shadow_word
);
    localparam int GAP_W = $clog2(T_MOD + 1);

    seq_state_e        state;
    mr1_cfg_t          cfg;
    logic [ADDR_W-1:0] mr1_word;
    logic              mr1_ok;
    logic [SEL_W-1:0]  pend_sel;
    logic [ADDR_W-1:0] pend_word;
    logic              pend_follow;
    logic [ADDR_W-1:0] mr0_shadow;
    logic              shadow_dll_off;
    logic              mrd_last, mod_last;
    logic              bus_free, issue_main, issue_follow, issue;
    logic [SEL_W-1:0]  issue_sel;
    logic [ADDR_W-1:0] issue_word;

    assign cfg = '{dll_off: req_dll_off, drive: req_drive, addlat: req_addlat,
                   term: req_term, wlev: req_wlev, tdqs_en: req_tdqs,
                   out_off: req_out_off};

    mrs_mr1_pack #(.ADDR_W(ADDR_W)) u_pack (
        .cfg   (cfg),
        .word  (mr1_word),
        .legal (mr1_ok)
    );

    assign bus_free     = banks_idle && !burst_active;
    assign issue_main   = (state == ST_HOLD) && bus_free;
    assign issue_follow = (state == ST_GAP) && mrd_last;
    assign issue        = issue_main || issue_follow;

    always_comb begin
        if (issue_follow) begin
            issue_sel  = SEL_W'(MR_ID0);
            issue_word = mr0_shadow;
            issue_word[B_DLL_RESET] = 1'b1;
        end else begin
            issue_sel  = pend_sel;
            issue_word = pend_word;
        end
    end

    mrs_shadow #(.ADDR_W(ADDR_W)) u_shadow (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (issue),
        .wr_sel      (issue_sel),
        .wr_data     (issue_word),
        .rd_sel      (shadow_sel),
        .rd_data     (shadow_word),
        .mr0_word    (mr0_shadow),
        .mr1_dll_off (shadow_dll_off)
    );

    mrs_gap_timer #(.T_MRD(T_MRD), .T_MOD(T_MOD)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (issue),
        .mrd_last (mrd_last),
        .mod_last (mod_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            pend_sel    <= '0;
            pend_word   <= '0;
            pend_follow <= 1'b0;
            busy        <= 1'b0;
            err         <= 1'b0;
            cmd_mrs     <= 1'b0;
            cmd_ba      <= '0;
            cmd_addr    <= '0;
        end else begin
            err     <= 1'b0;
            cmd_mrs <= 1'b0;
            if (issue) begin
                cmd_mrs  <= 1'b1;
                cmd_ba   <= {1'b0, issue_sel};
                cmd_addr <= issue_word;
            end
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (req_sel == SEL_W'(MR_ID1) && !mr1_ok) begin
                            err <= 1'b1;
                        end else begin
                            pend_sel    <= req_sel;
                            pend_word   <= (req_sel == SEL_W'(MR_ID1)) ? mr1_word : req_addr;
                            pend_follow <= (req_sel == SEL_W'(MR_ID1)) && shadow_dll_off
                                           && !req_dll_off;
                            busy        <= 1'b1;
                            state       <= ST_HOLD;
                        end
                    end
                end
                ST_HOLD: begin
                    if (bus_free)
                        state <= pend_follow ? ST_GAP : ST_SETTLE;
                end
                ST_GAP: begin
                    if (mrd_last) begin
                        pend_follow <= 1'b0;
                        state       <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (mod_last) begin
                        busy  <= 1'b0;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // cycles since the last command, kept only for the spacing checks
    logic [GAP_W-1:0] since_cmd;
    always_ff @(posedge clk) begin
        if (rst)
            since_cmd <= GAP_W'(T_MOD);
        else if (cmd_mrs)
            since_cmd <= GAP_W'(1);
        else if (since_cmd != GAP_W'(T_MOD))
            since_cmd <= since_cmd + 1'b1;
    end

    // R3: reserved register-1 bits stay low on the bus
    p_mr1_reserved_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_mrs && cmd_ba == 3'b001) |->
            (!cmd_addr[MR1_TOP] && !cmd_addr[10] && !cmd_addr[8] && !cmd_ba[2]));

    // R8: a reject drives nothing and leaves busy low
    p_reject_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        err |-> (!cmd_mrs && !busy));

    // R9: no command while banks are busy or a burst runs
    p_wait_bus_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && !bus_free) |=> !cmd_mrs);

    // R10: minimum spacing between commands
    p_mrd_gap_r10: assert property (@(posedge clk) disable iff (rst)
        cmd_mrs |-> (since_cmd >= GAP_W'(T_MRD)));

    // R10: busy is released exactly T_MOD cycles after the last command
    p_mod_release_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (since_cmd == GAP_W'(T_MOD)));
endmodule

// File: tb/mrs_seq_bench.sv
module mrs_seq_bench;
    localparam int ADDR_W = 14;
    localparam int T_MRD  = 3;
    localparam int T_MOD  = 7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [1:0]        req_sel = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_dll_off = 1'b0;
    logic [1:0]        req_drive = '0;
    logic [1:0]        req_addlat = '0;
    logic [2:0]        req_term = '0;
    logic              req_wlev = 1'b0;
    logic              req_tdqs = 1'b0;
    logic              req_out_off = 1'b0;
    logic              banks_idle = 1'b1;
    logic              burst_active = 1'b0;
    logic              cmd_mrs;
    logic [2:0]        cmd_ba;
    logic [ADDR_W-1:0] cmd_addr;
    logic              busy, err;
    logic [1:0]        shadow_sel = '0;
    logic [ADDR_W-1:0] shadow_word;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;   // 125 MHz

    mrs_seq #(.ADDR_W(ADDR_W), .T_MRD(T_MRD), .T_MOD(T_MOD)) u_mrs_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_sel(req_sel),
        .req_addr(req_addr), .req_dll_off(req_dll_off), .req_drive(req_drive),
        .req_addlat(req_addlat), .req_term(req_term), .req_wlev(req_wlev),
        .req_tdqs(req_tdqs), .req_out_off(req_out_off), .banks_idle(banks_idle),
        .burst_active(burst_active), .cmd_mrs(cmd_mrs), .cmd_ba(cmd_ba),
        .cmd_addr(cmd_addr), .busy(busy), .err(err), .shadow_sel(shadow_sel),
        .shadow_word(shadow_word)
    );

    typedef struct packed {
        logic       dll;
        logic [1:0] drv;
        logic [1:0] al;
        logic [2:0] rtt;
        logic       wl;
        logic       tdqs;
        logic       qoff;
        logic       rej;
        logic [13:0] word;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'b00, 2'b00, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 14'h0000},
        '{1'b0, 2'b01, 2'b01, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 14'h000E},
        '{1'b0, 2'b00, 2'b10, 3'b100, 1'b0, 1'b1, 1'b0, 1'b0, 14'h0A10},
        '{1'b0, 2'b00, 2'b00, 3'b101, 1'b0, 1'b0, 1'b1, 1'b0, 14'h1204},
        '{1'b0, 2'b10, 2'b00, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 14'h0000},
        '{1'b0, 2'b00, 2'b11, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 14'h0000},
        '{1'b0, 2'b00, 2'b00, 3'b110, 1'b0, 1'b0, 1'b0, 1'b1, 14'h0000},
        '{1'b0, 2'b00, 2'b00, 3'b111, 1'b0, 1'b0, 1'b1, 1'b1, 14'h0000},
        '{1'b0, 2'b00, 2'b00, 3'b010, 1'b1, 1'b0, 1'b0, 1'b0, 14'h00C0},
        '{1'b0, 2'b00, 2'b00, 3'b000, 1'b1, 1'b0, 1'b0, 1'b1, 14'h0000},
        '{1'b0, 2'b00, 2'b00, 3'b100, 1'b1, 1'b0, 1'b0, 1'b1, 14'h0000},
        '{1'b0, 2'b00, 2'b00, 3'b100, 1'b1, 1'b0, 1'b1, 1'b0, 14'h1280},
        '{1'b1, 2'b01, 2'b10, 3'b011, 1'b0, 1'b0, 1'b0, 1'b0, 14'h0057}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic shadow_chk(input string tag, input logic [1:0] sel, input logic [13:0] exp);
        shadow_sel = sel;
        #1;
        chk(tag, 32'(shadow_word), 32'(exp));
    endtask

    // pulse a request for one cycle; returns at the negedge after acceptance
    task automatic pulse_req(input logic [1:0] sel);
        @(negedge clk);
        req_sel   = sel;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // called at the negedge of a command cycle: checks busy release at T_MOD
    task automatic chk_release(input string tag);
        repeat (T_MOD - 1) @(negedge clk);
        chk({tag, " busy before T_MOD"}, 32'(busy), 32'd1);
        @(negedge clk);
        chk({tag, " busy released at T_MOD"}, 32'(busy), 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [13:0] last_mr1;
        last_mr1 = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        chk("R12 reset busy", 32'(busy), 32'd0);
        chk("R8 reset err", 32'(err), 32'd0);
        chk("R10 reset cmd", 32'(cmd_mrs), 32'd0);
        for (int s = 0; s < 4; s++) shadow_chk("R12 reset shadow", 2'(s), 14'h0);

        // R9 hold until banks idle and no burst; R1 register 2 word
        banks_idle = 1'b0;
        req_addr   = 14'h0018;
        pulse_req(2'b10);
        chk("R9 busy after accept", 32'(busy), 32'd1);
        for (int i = 0; i < 4; i++) begin
            chk("R9 no cmd while banks busy", 32'(cmd_mrs), 32'd0);
            @(negedge clk);
        end
        banks_idle   = 1'b1;
        burst_active = 1'b1;
        @(negedge clk);
        chk("R9 no cmd during burst", 32'(cmd_mrs), 32'd0);
        burst_active = 1'b0;
        @(negedge clk);
        chk("R9 cmd after bus free", 32'(cmd_mrs), 32'd1);
        chk("R1 bank address reg2", 32'(cmd_ba), 32'd2);
        chk("R1 address word reg2", 32'(cmd_addr), 32'h0018);
        @(negedge clk);
        chk("R10 single-cycle strobe", 32'(cmd_mrs), 32'd0);
        repeat (T_MOD - 2) @(negedge clk);
        chk("R10 busy before T_MOD", 32'(busy), 32'd1);
        @(negedge clk);
        chk("R10 busy released at T_MOD", 32'(busy), 32'd0);
        shadow_chk("R12 shadow reg2", 2'b10, 14'h0018);

        // register-1 vector table
        for (int v = 0; v < NV; v++) begin
            req_addr    = '1;   // R3: must be ignored
            req_dll_off = VECS[v].dll;
            req_drive   = VECS[v].drv;
            req_addlat  = VECS[v].al;
            req_term    = VECS[v].rtt;
            req_wlev    = VECS[v].wl;
            req_tdqs    = VECS[v].tdqs;
            req_out_off = VECS[v].qoff;
            pulse_req(2'b01);
            if (VECS[v].rej) begin
                chk("R4 R5 R6 R7 reject pulse", 32'(err), 32'd1);
                chk("R8 busy low on reject", 32'(busy), 32'd0);
                @(negedge clk);
                chk("R8 err single cycle", 32'(err), 32'd0);
                chk("R8 no command on reject", 32'(cmd_mrs), 32'd0);
                shadow_chk("R8 shadow unchanged", 2'b01, last_mr1);
            end else begin
                chk("R7 accepted no err", 32'(err), 32'd0);
                chk("R9 busy on accept", 32'(busy), 32'd1);
                @(negedge clk);
                chk("R9 cmd with bus free", 32'(cmd_mrs), 32'd1);
                chk("R1 bank address reg1", 32'(cmd_ba), 32'd1);
                chk("R2 R3 packed word", 32'(cmd_addr), 32'(VECS[v].word));
                chk_release("R10 reg1");
                last_mr1 = VECS[v].word;
                shadow_chk("R12 shadow reg1", 2'b01, last_mr1);
            end
        end

        // R12 request while busy is ignored; R1 register 3
        req_addr = 14'h02A5;
        pulse_req(2'b11);
        @(negedge clk);
        chk("R1 bank address reg3", 32'(cmd_ba), 32'd3);
        req_addr  = 14'h1111;
        req_sel   = 2'b11;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (T_MOD) @(negedge clk);
        chk("R12 busy-time request dropped", 32'(busy), 32'd0);
        shadow_chk("R12 shadow reg3 keeps first", 2'b11, 14'h02A5);

        // register 0 word, then DLL re-enable triggers reset write
        req_addr = 14'h0052;
        pulse_req(2'b00);
        @(negedge clk);
        chk("R1 bank address reg0", 32'(cmd_ba), 32'd0);
        chk_release("R10 reg0");

        req_dll_off = 1'b0; req_drive = 2'b00; req_addlat = 2'b00;
        req_term = 3'b000; req_wlev = 1'b0; req_tdqs = 1'b0; req_out_off = 1'b0;
        pulse_req(2'b01);
        @(negedge clk);
        chk("R11 reg1 cmd", 32'(cmd_mrs), 32'd1);
        chk("R11 reg1 word", 32'(cmd_addr), 32'h0000);
        for (int i = 1; i < T_MRD; i++) begin
            @(negedge clk);
            chk("R11 gap before reset write", 32'(cmd_mrs), 32'd0);
        end
        @(negedge clk);
        chk("R11 follow-up at T_MRD", 32'(cmd_mrs), 32'd1);
        chk("R11 follow-up bank", 32'(cmd_ba), 32'd0);
        chk("R11 follow-up word", 32'(cmd_addr), 32'h0152);
        chk_release("R10 after follow-up");
        shadow_chk("R11 reg0 shadow", 2'b00, 14'h0152);

        // DLL stays enabled: no follow-up
        pulse_req(2'b01);
        @(negedge clk);
        chk("R11 plain reg1 cmd", 32'(cmd_mrs), 32'd1);
        for (int i = 0; i < T_MOD; i++) begin
            @(negedge clk);
            chk("R11 no follow-up when already enabled", 32'(cmd_mrs), 32'd0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule